// File: doc/BRIEF.md
# Programmable-Priority DMA Channel Arbiter

This block decides which of seven DMA channels may use the shared memory bus. Software programs a single 32-bit configuration word. In that word each channel has a 4-bit slot made of a 3-bit priority level and an enable bit. On each decision the arbiter considers only channels that are both enabled and requesting. It grants the one whose priority value is numerically smallest.

The grant is registered. Once issued, it stays with the channel until that channel pulses a release. The arbiter then leaves the bus idle for one cycle and arbitrates again on the following edge. Register writes use a plain write strobe with data, and the current register value is always visible on a read port. No grant is started on an edge where the register is being written, so a decision never mixes old and new settings.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After synchronous reset the configuration word reads 0x07654321, so channel N has priority N+1 and every channel is disabled. No grant is active.
- R2: A write stores all 32 data bits, including bits 28 to 31, which have no function. The read port shows the stored value from the cycle after the write.
- R3: Channel N is eligible only when its request is high and its enable bit (bit 4N+3) is 1. A channel that is not eligible is never granted.
- R4: Among eligible channels, the one with the smallest priority value (bits 4N to 4N+2, where 0 is most urgent) is granted.
- R5: When eligible channels share the smallest priority value, the one with the highest channel number is granted.
- R6: The grant is registered. It appears on the edge after the eligible requests are sampled. The grant vector is one-hot with bit N for channel N, the channel number is its binary encoding, and a valid flag is high exactly while a grant is held.
- R7: A held grant does not change until the release input is high at an edge, whatever happens to requests or the register.
- R8: A release ends the grant at that edge. The arbiter is idle for one cycle and re-arbitrates at the next edge. A release while idle is ignored.
- R9: No new grant is issued at an edge where the write strobe is high. Arbitration always uses the register value from before that edge.
- R10: Bits 28 to 31 of the configuration word have no effect on which channel is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Data to write |
| cfg_rd_data | output | 32 | Current configuration word |
| chan_req | input | 7 | Request line for each channel |
| grant_release | input | 1 | Pulse from the granted channel to give up the bus |
| grant_vec | output | 7 | One-hot grant |
| grant_id | output | 3 | Encoded number of the granted channel (0 when idle) |
| grant_valid | output | 1 | A grant is currently held |

## Verification
Two functions can fall in the same cycle: a configuration write and the decision to issue a new grant. A release arriving together with a write also forces both paths to act at one edge. Directed steps put a write on the very edge where enabled requests first appear, and another write together with a release. Random traffic then mixes writes, requests and releases freely. A bench model applies the old register value to the decision, suppresses the grant on a write edge, and compares grant, channel number and read-back on every cycle.

// File: rtl/dma_arb_pkg.sv
// Package: shared sizes and the reset value of the arbiter configuration word.
// Assumes seven channels, each with a 4-bit slot of priority plus enable.
package dma_arb_pkg;
    localparam int          NUM_CH  = 7;
    localparam int          PRIO_W  = 3;
    localparam int          SLOT_W  = PRIO_W + 1;
    localparam int          CFG_W   = 32;
    localparam int          ID_W    = $clog2(NUM_CH);
    localparam logic [31:0] CFG_RST = 32'h0765_4321;
endpackage

// File: rtl/dma_arb_cfg_reg.sv
// Module: configuration word storage.
// Holds every bit written, including bits without a function; reset loads RST_VAL.
module dma_arb_cfg_reg #(
    parameter int          CFG_W   = dma_arb_pkg::CFG_W,
    parameter logic [31:0] RST_VAL = dma_arb_pkg::CFG_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    // Capture the full written word, or the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= RST_VAL[CFG_W-1:0];
        else if (wr_en) cfg_q <= wr_data;
    end

    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wr_data)));
    assert_hold_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/dma_arb_select.sv
// Module: combinational winner selection.
// Picks the eligible channel with the smallest priority value.
// A later channel wins when the values are equal.
module dma_arb_select #(
    parameter int NUM_CH = dma_arb_pkg::NUM_CH,
    parameter int PRIO_W = dma_arb_pkg::PRIO_W,
    parameter int ID_W   = dma_arb_pkg::ID_W
) (
    input  logic [NUM_CH-1:0]        elig,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     found,
    output logic [ID_W-1:0]          win_id
);
    logic [PRIO_W-1:0] best;

    // Scan upward; "<=" lets a higher-numbered channel take a tie.
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        best   = '1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
                found  = 1'b1;
                best   = prio_flat[i*PRIO_W +: PRIO_W];
                win_id = ID_W'(i);
            end
        end
    end

    always_comb begin
        if (found) assert_winner_eligible_R3: assert (elig[win_id]);
        else       assert_no_winner_R3: assert (elig == '0);
    end
endmodule

// File: rtl/dma_arb_grant_ctl.sv
// Module: registered grant holder.
// When idle and not blocked by a write, it latches the selected winner.
// It keeps the grant until a release, then idles for one cycle.
module dma_arb_grant_ctl #(
    parameter int NUM_CH = dma_arb_pkg::NUM_CH,
    parameter int ID_W   = dma_arb_pkg::ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_off,
    input  logic              found,
    input  logic [ID_W-1:0]   win_id,
    input  logic [NUM_CH-1:0] elig,
    input  logic              release_i,
    output logic [NUM_CH-1:0] grant,
    output logic [ID_W-1:0]   grant_id,
    output logic              grant_valid
);
    // Grant state: idle -> granted on a winner, granted -> idle on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_id    <= '0;
            grant_valid <= 1'b0;
        end else if (grant_valid) begin
            if (release_i) begin
                grant       <= '0;
                grant_id    <= '0;
                grant_valid <= 1'b0;
            end
        end else if (found && !hold_off) begin
            grant       <= NUM_CH'(1) << win_id;
            grant_id    <= win_id;
            grant_valid <= 1'b1;
        end
    end

    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_valid == (grant != '0)));
    assert_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(elig) & grant) != '0));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !release_i) |=> (grant_valid && $stable(grant)));
    assert_release_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && release_i) |=> !grant_valid);
    assert_no_grant_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && hold_off) |=> !grant_valid);
endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: top of the programmable-priority DMA channel arbiter.
// Splits the configuration word into per-channel priority and enable fields.
// Bits above the channel slots are stored but never decoded.
module dma_prio_arbiter
    import dma_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic              grant_release,
    output logic [NUM_CH-1:0] grant_vec,
    output logic [ID_W-1:0]   grant_id,
    output logic              grant_valid
);
    logic [CFG_W-1:0]         cfg_q;
    logic [NUM_CH-1:0]        ch_en;
    logic [NUM_CH*PRIO_W-1:0] prio_flat;
    logic [NUM_CH-1:0]        elig;
    logic                     found;
    logic [ID_W-1:0]          win_id;

    dma_arb_cfg_reg #(.CFG_W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
        .wr_data(cfg_wr_data), .cfg_q(cfg_q)
    );

    // Field decode: one slot per channel, enable on the slot's top bit.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        assign prio_flat[g*PRIO_W +: PRIO_W] = cfg_q[g*SLOT_W +: PRIO_W];
        assign ch_en[g] = cfg_q[g*SLOT_W + PRIO_W];
    end

    assign elig        = chan_req & ch_en;
    assign cfg_rd_data = cfg_q;

    dma_arb_select #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
        .elig(elig), .prio_flat(prio_flat), .found(found), .win_id(win_id)
    );

    dma_arb_grant_ctl #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_gnt (
        .clk(clk), .rst_n(rst_n), .hold_off(cfg_wr_en), .found(found),
        .win_id(win_id), .elig(elig), .release_i(grant_release),
        .grant(grant_vec), .grant_id(grant_id), .grant_valid(grant_valid)
    );
endmodule

// File: tb/dma_prio_arbiter_tb.sv
// Bench: directed corner cases, then seeded random traffic.
// Every cycle is checked against a behavioural model.
module dma_prio_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic [6:0]  chan_req = '0;
    logic        grant_release = 1'b0;
    logic [6:0]  grant_vec;
    logic [2:0]  grant_id;
    logic        grant_valid;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_cfg;
    int          m_gnt;

    always #2 clk = ~clk;

    dma_prio_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .chan_req(chan_req), .grant_release(grant_release),
        .grant_vec(grant_vec), .grant_id(grant_id), .grant_valid(grant_valid)
    );

    // Model winner: scan from the top channel down, replace only on strictly smaller.
    function automatic int pick(input logic [31:0] cfg, input logic [6:0] rq);
        int w = -1;
        int bp = 8;
        for (int c = 6; c >= 0; c--) begin
            if (rq[c] && cfg[4*c+3] && int'(cfg[4*c +: 3]) < bp) begin
                bp = int'(cfg[4*c +: 3]);
                w = c;
            end
        end
        return w;
    endfunction

    task automatic compare(input string tag);
        logic [6:0] ev = (m_gnt < 0) ? 7'd0 : 7'(1 << m_gnt);
        logic [2:0] ei = (m_gnt < 0) ? 3'd0 : 3'(m_gnt);
        n_chk++;
        if (grant_vec !== ev || grant_id !== ei || grant_valid !== (m_gnt >= 0)
            || cfg_rd_data !== m_cfg) begin
            n_bad++;
            $display("FAIL %s: gnt=%b id=%0d v=%b cfg=%h expected gnt=%b id=%0d v=%b cfg=%h",
                     tag, grant_vec, grant_id, grant_valid, cfg_rd_data,
                     ev, ei, (m_gnt >= 0), m_cfg);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, check at the next falling edge.
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic [6:0] rq,
                       input logic rl, input string tag);
        cfg_wr_en = wr; cfg_wr_data = wd; chan_req = rq; grant_release = rl;
        if (m_gnt >= 0) begin
            if (rl) m_gnt = -1;
        end else if (!wr) begin
            m_gnt = pick(m_cfg, rq);
        end
        if (wr) m_cfg = wd;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        m_cfg = 32'h0765_4321;
        m_gnt = -1;
        compare("R1");
        rst_n = 1'b1;
        cyc(0, 0, 7'h7f, 0, "R3");               // all disabled: nothing granted
        cyc(1, 32'h0FED_CBA9, 7'h7f, 0, "R9");   // write edge blocks grant
        cyc(0, 0, 7'h7f, 0, "R4");               // channel 0 (priority 1)
        cyc(0, 0, 7'h7f, 0, "R7");
        cyc(0, 0, 7'h7e, 0, "R7");               // request dropped, grant held
        cyc(0, 0, 7'h7e, 1, "R8");               // release -> idle cycle
        cyc(0, 0, 7'h7e, 0, "R4");               // channel 1
        cyc(1, 32'h0FBD_CBA9, 7'h7e, 1, "R8");   // release with write together
        cyc(0, 0, 7'b0100100, 0, "R5");          // tie at 3: channel 5 wins
        cyc(1, 32'h0FED_CBA9, 7'h7f, 0, "R7");   // write while held: no change
        cyc(0, 0, 7'h00, 1, "R8");
        cyc(0, 0, 7'h00, 1, "R8");               // release while idle ignored
        cyc(1, 32'hFFBD_CBA9, 7'h00, 0, "R2");   // upper bits stored
        cyc(0, 0, 7'b1100000, 0, "R10");         // upper bits set: channel 5
        cyc(0, 0, 7'h00, 1, "R8");
        cyc(1, 32'h0FBD_CBA0, 7'h00, 0, "R2");   // channel 0 priority 0, disabled
        cyc(0, 0, 7'h7f, 0, "R3");               // channel 1 wins
        cyc(0, 0, 7'h00, 1, "R8");
        for (int k = 0; k < 3000; k++) begin
            logic wr = ($urandom % 10) == 0;
            logic [31:0] wd = $urandom;
            logic [6:0] rq = 7'($urandom);
            logic rl = ($urandom % 4) == 0;
            if (($urandom % 3) == 0) wd = wd | 32'h0888_8888;
            cyc(wr, wd, rq, rl, wr ? "R9" : "R6");
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule